// File: doc/BRIEF.md
# Short-Vector Register Address Sequencer

This block produces the register indices used by each step of a short-vector floating-point data-processing operation. A one-cycle start pulse captures a precision select, a destination and two source register numbers, a length code and a stride code. From the next cycle on, the block presents one iteration per clock: three register indices, a valid strobe and a final-iteration flag.

Every operand advances by the stride but stays inside its own bank. When an index passes the top of its bank, it returns to the bottom of that same bank. The bank geometry follows the precision. Single precision uses four banks of eight registers, and double precision uses eight banks of four. Destinations in the lowest bank run as a single scalar step. Sources in that bank stay fixed. In double precision the bank starting at register 16 counts as lowest as well.

A combinational side output gives the destination index of the current iteration as it would be with plain linear addressing and no bank wrap. This serves as a comparison point.

Top module: `svec_addr_seq`

## Requirements
- R1: While rst_ni is low, iter_vld_o, iter_last_o, busy_o and illegal_o are 0.
- R2: With dbl_i=0 the bank of an index is index[4:3]. After each iteration an operand moves to base + ((offset + step) mod 8), where offset is index[2:0] and base is the index with those bits cleared.
- R3: With dbl_i=1 the bank of an index is index[4:2]. The next index is base + ((offset + step) mod 4), where offset is index[1:0].
- R4: A legal, non-scalar operation runs len_i + 1 iterations (len_i from 0 to 7 gives 1 to 8).
- R5: A start accepted at a clock edge shows its first iteration in the following cycle. Iterations then follow on consecutive cycles. busy_o equals iter_vld_o.
- R6: iter_last_o is high on the final iteration only. In the next cycle iter_vld_o and busy_o are 0.
- R7: stride_i=2'b00 gives a step of 1 and stride_i=2'b11 gives a step of 2. The codes 2'b01 and 2'b10 are illegal.
- R8: With dbl_i=1, a len_i outside 1..3 is illegal, which means a vector length outside 2..4. This check comes before the scalar rule.
- R9: An illegal start pulses illegal_o for exactly the one cycle after the start. It produces no iteration, and busy_o stays 0.
- R10: A legal operation whose destination lies in bank 0 runs exactly one iteration with iter_last_o high. Bank 0 is indices 0–7 in single precision. In double precision, bank 0 covers indices 0–3 and bank 4 covers indices 16–19, and bank 4 follows the same rule.
- R11: A source in a bank that R10 names keeps its start index on every iteration.
- R12: start_i is ignored while busy_o is 1, including during the final iteration.
- R13: During iteration k (counted from 0), lin_dst_o = (start destination + k * step) mod 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled while idle |
| dbl_i | input | 1 | 1 selects double-precision bank geometry |
| len_i | input | 3 | Vector length minus one |
| stride_i | input | 2 | Stride code |
| dst_i | input | 5 | Starting destination index |
| src1_i | input | 5 | Starting first source index |
| src2_i | input | 5 | Starting second source index |
| busy_o | output | 1 | Iterations in progress |
| iter_vld_o | output | 1 | Current indices are valid |
| iter_last_o | output | 1 | Current iteration is the final one |
| illegal_o | output | 1 | One-cycle pulse for a rejected configuration |
| dst_o | output | 5 | Destination index of this iteration |
| src1_o | output | 5 | First source index of this iteration |
| src2_o | output | 5 | Second source index of this iteration |
| lin_dst_o | output | 5 | Destination index under linear addressing |

## Verification
The hardest case to reach is a start pulse that lands while the final iteration is on the outputs. If it were accepted there, it would merge with the end of the running operation instead of being dropped. The bench drives the pulse on the falling edge of the cycle that shows iter_last_o high, and does the same in the middle of a run with an illegal configuration on the other inputs. It then checks that the running sequence is unchanged, that no illegal pulse appears and that the block goes idle. A second hard case puts a held source next to a destination that wraps, with a step of two in both geometries. The stimulus table pairs scalar-bank sources with wrapping destinations for this.

// File: rtl/svec_pkg.sv
`timescale 1ns/1ps
package svec_pkg;
  localparam int unsigned NUM_REGS       = 32;
  localparam int unsigned REG_IDX_W      = $clog2(NUM_REGS);
  localparam int unsigned NUM_OPS        = 3;
  localparam int unsigned LEN_W          = 3;
  localparam int unsigned STRIDE_W       = 2;
  localparam int unsigned STEP_W         = 2;
  localparam int unsigned SP_BANK_SZ     = 8;
  localparam int unsigned DP_BANK_SZ     = 4;
  localparam int unsigned SP_OFF_W       = $clog2(SP_BANK_SZ);
  localparam int unsigned DP_OFF_W       = $clog2(DP_BANK_SZ);
  localparam int unsigned DP_NUM_BANKS   = NUM_REGS / DP_BANK_SZ;
  localparam int unsigned DP_MIRROR_BANK = DP_NUM_BANKS / 2;

  typedef logic [REG_IDX_W-1:0] reg_idx_t;

  typedef enum logic [STRIDE_W-1:0] {
    STRIDE_ONE  = 2'b00,
    STRIDE_RSV1 = 2'b01,
    STRIDE_RSV2 = 2'b10,
    STRIDE_TWO  = 2'b11
  } stride_e;

  typedef struct packed {
    logic              legal;
    logic              scalar;
    logic [LEN_W:0]    n_iter;
    logic [STEP_W-1:0] step;
  } cfg_t;

  // lowest bank, or its double-precision mirror in the upper half
  function automatic logic in_scalar_bank(input reg_idx_t idx, input logic dbl);
    logic [REG_IDX_W-DP_OFF_W-1:0] dp_bank;
    logic [REG_IDX_W-SP_OFF_W-1:0] sp_bank;
    dp_bank = idx[REG_IDX_W-1:DP_OFF_W];
    sp_bank = idx[REG_IDX_W-1:SP_OFF_W];
    if (dbl) return (dp_bank == '0) ||
                    (dp_bank == (REG_IDX_W-DP_OFF_W)'(DP_MIRROR_BANK));
    return sp_bank == '0;
  endfunction
endpackage

// File: rtl/svec_cfg_decode.sv
`timescale 1ns/1ps
module svec_cfg_decode
  import svec_pkg::*;
#(
  parameter int unsigned DP_MIN_LEN = 2,
  parameter int unsigned DP_MAX_LEN = 4
) (
  input  logic                dbl_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  reg_idx_t            dst_i,
  output cfg_t                cfg_o
);
  logic [LEN_W:0]    vec_len;
  logic [STEP_W-1:0] step;
  logic              stride_ok;
  logic              dp_len_ok;
  logic              scalar;

  always_comb begin
    vec_len = (LEN_W+1)'(len_i) + (LEN_W+1)'(1);
    unique case (stride_e'(stride_i))
      STRIDE_ONE: begin step = STEP_W'(1); stride_ok = 1'b1; end
      STRIDE_TWO: begin step = STEP_W'(2); stride_ok = 1'b1; end
      default:    begin step = '0;         stride_ok = 1'b0; end
    endcase
    dp_len_ok = (vec_len >= (LEN_W+1)'(DP_MIN_LEN)) &&
                (vec_len <= (LEN_W+1)'(DP_MAX_LEN));
    scalar    = in_scalar_bank(dst_i, dbl_i);

    cfg_o.legal  = stride_ok && (!dbl_i || dp_len_ok);
    cfg_o.scalar = scalar;
    cfg_o.n_iter = scalar ? (LEN_W+1)'(1) : vec_len;
    cfg_o.step   = step;
  end
endmodule

// File: rtl/svec_bank_step.sv
`timescale 1ns/1ps
module svec_bank_step
  import svec_pkg::*;
(
  input  reg_idx_t          addr_i,
  input  logic              dbl_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              hold_i,
  output reg_idx_t          nxt_o
);
  logic [SP_OFF_W-1:0] sp_off;
  logic [DP_OFF_W-1:0] dp_off;

  // offset add truncates to the bank width: that is the wrap
  always_comb begin
    sp_off = addr_i[SP_OFF_W-1:0] + SP_OFF_W'(step_i);
    dp_off = addr_i[DP_OFF_W-1:0] + DP_OFF_W'(step_i);
    if (hold_i)     nxt_o = addr_i;
    else if (dbl_i) nxt_o = {addr_i[REG_IDX_W-1:DP_OFF_W], dp_off};
    else            nxt_o = {addr_i[REG_IDX_W-1:SP_OFF_W], sp_off};
  end
endmodule

// File: rtl/svec_iter_ctrl.sv
`timescale 1ns/1ps
module svec_iter_ctrl
  import svec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  cfg_t             cfg_i,
  output logic             vld_o,
  output logic             last_o,
  output logic             load_o,
  output logic             adv_o,
  output logic [LEN_W-1:0] idx_o,
  output logic             illegal_o
);
  logic             vld_q;
  logic [LEN_W:0]   remain_q;
  logic [LEN_W-1:0] idx_q;
  logic             illegal_q;
  logic             accept;

  assign accept = start_i && !vld_q;
  assign load_o = accept && cfg_i.legal;
  assign adv_o  = vld_q && (remain_q != '0);
  assign last_o = vld_q && (remain_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q     <= 1'b0;
      remain_q  <= '0;
      idx_q     <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= accept && !cfg_i.legal;
      if (load_o) begin
        vld_q    <= 1'b1;
        remain_q <= cfg_i.n_iter - (LEN_W+1)'(1);
        idx_q    <= '0;
      end else if (adv_o) begin
        remain_q <= remain_q - (LEN_W+1)'(1);
        idx_q    <= idx_q + LEN_W'(1);
      end else if (last_o) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign vld_o     = vld_q;
  assign idx_o     = idx_q;
  assign illegal_o = illegal_q;
endmodule

// File: rtl/svec_addr_seq.sv
`timescale 1ns/1ps
module svec_addr_seq
  import svec_pkg::*;
#(
  parameter int unsigned DP_MIN_LEN = 2,
  parameter int unsigned DP_MAX_LEN = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 dbl_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic [STRIDE_W-1:0]  stride_i,
  input  logic [REG_IDX_W-1:0] dst_i,
  input  logic [REG_IDX_W-1:0] src1_i,
  input  logic [REG_IDX_W-1:0] src2_i,
  output logic                 busy_o,
  output logic                 iter_vld_o,
  output logic                 iter_last_o,
  output logic                 illegal_o,
  output logic [REG_IDX_W-1:0] dst_o,
  output logic [REG_IDX_W-1:0] src1_o,
  output logic [REG_IDX_W-1:0] src2_o,
  output logic [REG_IDX_W-1:0] lin_dst_o
);
  cfg_t              cfg;
  logic              vld;
  logic              load;
  logic              adv;
  logic [LEN_W-1:0]  idx;

  logic              dbl_q;
  logic [STEP_W-1:0] step_q;
  reg_idx_t          lin_base_q;
  logic [NUM_OPS-1:0] hold_q;
  reg_idx_t          op_in    [NUM_OPS];
  reg_idx_t          addr_q   [NUM_OPS];
  reg_idx_t          addr_nxt [NUM_OPS];

  assign op_in[0] = dst_i;
  assign op_in[1] = src1_i;
  assign op_in[2] = src2_i;

  svec_cfg_decode #(
    .DP_MIN_LEN(DP_MIN_LEN),
    .DP_MAX_LEN(DP_MAX_LEN)
  ) u_dec (
    .dbl_i   (dbl_i),
    .len_i   (len_i),
    .stride_i(stride_i),
    .dst_i   (dst_i),
    .cfg_o   (cfg)
  );

  svec_iter_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .cfg_i    (cfg),
    .vld_o    (vld),
    .last_o   (iter_last_o),
    .load_o   (load),
    .adv_o    (adv),
    .idx_o    (idx),
    .illegal_o(illegal_o)
  );

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    svec_bank_step u_step (
      .addr_i(addr_q[g]),
      .dbl_i (dbl_q),
      .step_i(step_q),
      .hold_i(hold_q[g]),
      .nxt_o (addr_nxt[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbl_q      <= 1'b0;
      step_q     <= '0;
      lin_base_q <= '0;
      hold_q     <= '0;
      for (int i = 0; i < NUM_OPS; i++) addr_q[i] <= '0;
    end else if (load) begin
      dbl_q      <= dbl_i;
      step_q     <= cfg.step;
      lin_base_q <= dst_i;
      // destination is never held: a scalar destination ends after one step
      for (int i = 0; i < NUM_OPS; i++) begin
        addr_q[i] <= op_in[i];
        hold_q[i] <= (i != 0) && in_scalar_bank(op_in[i], dbl_i);
      end
    end else if (adv) begin
      for (int i = 0; i < NUM_OPS; i++) addr_q[i] <= addr_nxt[i];
    end
  end

  assign busy_o     = vld;
  assign iter_vld_o = vld;
  assign dst_o      = addr_q[0];
  assign src1_o     = addr_q[1];
  assign src2_o     = addr_q[2];
  assign lin_dst_o  = lin_base_q + REG_IDX_W'(idx) * REG_IDX_W'(step_q);
endmodule

// File: rtl/svec_addr_seq_chk.sv
`timescale 1ns/1ps
module svec_addr_seq_chk
  import svec_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic                 busy_o,
  input logic                 iter_vld_o,
  input logic                 iter_last_o,
  input logic                 illegal_o,
  input logic [REG_IDX_W-1:0] dst_o,
  input logic [REG_IDX_W-1:0] src1_o,
  input logic [REG_IDX_W-1:0] src2_o,
  input logic                 dbl_q,
  input logic [NUM_OPS-1:0]   hold_q
);
  a_r5_contiguous: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_vld_o && !iter_last_o |=> iter_vld_o);

  a_r6_idle_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_last_o |=> !iter_vld_o && !busy_o);

  a_r6_last_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_last_o |-> iter_vld_o);

  a_r9_illegal_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !iter_vld_o && !busy_o);

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> !illegal_o);

  a_r2_bank_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_vld_o && $past(iter_vld_o) && !dbl_q |->
      dst_o[REG_IDX_W-1:SP_OFF_W]  == $past(dst_o[REG_IDX_W-1:SP_OFF_W]) &&
      src1_o[REG_IDX_W-1:SP_OFF_W] == $past(src1_o[REG_IDX_W-1:SP_OFF_W]) &&
      src2_o[REG_IDX_W-1:SP_OFF_W] == $past(src2_o[REG_IDX_W-1:SP_OFF_W]));

  a_r3_bank_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_vld_o && $past(iter_vld_o) && dbl_q |->
      dst_o[REG_IDX_W-1:DP_OFF_W]  == $past(dst_o[REG_IDX_W-1:DP_OFF_W]) &&
      src1_o[REG_IDX_W-1:DP_OFF_W] == $past(src1_o[REG_IDX_W-1:DP_OFF_W]) &&
      src2_o[REG_IDX_W-1:DP_OFF_W] == $past(src2_o[REG_IDX_W-1:DP_OFF_W]));

  a_r11_src1_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_vld_o && $past(iter_vld_o) && hold_q[1] |-> $stable(src1_o));

  a_r11_src2_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_vld_o && $past(iter_vld_o) && hold_q[2] |-> $stable(src2_o));

  a_r12_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> !illegal_o);
endmodule

bind svec_addr_seq svec_addr_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .iter_vld_o (iter_vld_o),
  .iter_last_o(iter_last_o),
  .illegal_o  (illegal_o),
  .dst_o      (dst_o),
  .src1_o     (src1_o),
  .src2_o     (src2_o),
  .dbl_q      (dbl_q),
  .hold_q     (hold_q)
);

// File: tb/sim_svec_addr_seq.sv
`timescale 1ns/1ps
module sim_svec_addr_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       dbl_i = 1'b0;
  logic [2:0] len_i = '0;
  logic [1:0] stride_i = '0;
  logic [4:0] dst_i = '0, src1_i = '0, src2_i = '0;
  logic       busy_o, iter_vld_o, iter_last_o, illegal_o;
  logic [4:0] dst_o, src1_o, src2_o, lin_dst_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  svec_addr_seq u0 (
    .clk_i, .rst_ni, .start_i, .dbl_i, .len_i, .stride_i,
    .dst_i, .src1_i, .src2_i,
    .busy_o, .iter_vld_o, .iter_last_o, .illegal_o,
    .dst_o, .src1_o, .src2_o, .lin_dst_o
  );

  // {dbl, len, stride, dst, src1, src2}
  localparam int NVEC = 12;
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b0, 3'd5, 2'b00, 5'd11, 5'd22, 5'd31},
    {1'b0, 3'd7, 2'b11, 5'd9,  5'd13, 5'd30},
    {1'b0, 3'd2, 2'b00, 5'd24, 5'd0,  5'd5 },
    {1'b0, 3'd0, 2'b00, 5'd12, 5'd1,  5'd2 },
    {1'b1, 3'd3, 2'b00, 5'd6,  5'd10, 5'd29},
    {1'b1, 3'd1, 2'b11, 5'd22, 5'd17, 5'd31},
    {1'b1, 3'd2, 2'b11, 5'd30, 5'd9,  5'd13},
    {1'b0, 3'd4, 2'b00, 5'd3,  5'd20, 5'd21},
    {1'b1, 3'd3, 2'b00, 5'd18, 5'd2,  5'd27},
    {1'b0, 3'd3, 2'b01, 5'd12, 5'd20, 5'd28},
    {1'b1, 3'd0, 2'b00, 5'd10, 5'd20, 5'd28},
    {1'b1, 3'd4, 2'b00, 5'd10, 5'd20, 5'd28}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int bsize(input bit dbl);
    return dbl ? 4 : 8;
  endfunction

  function automatic bit low_bank(input int a, input bit dbl);
    int b;
    b = a / bsize(dbl);
    return (b == 0) || (dbl && b == 4);
  endfunction

  function automatic int exp_idx(input int a, input bit dbl, input int step,
                                 input int k, input bit hold);
    int bs;
    bs = bsize(dbl);
    if (hold) return a;
    return (a / bs) * bs + ((a % bs) + k * step) % bs;
  endfunction

  task automatic drive_start(input bit dbl, input int len, input int str,
                             input int d, input int s1, input int s2);
    @(negedge clk_i);
    dbl_i = dbl; len_i = 3'(len); stride_i = 2'(str);
    dst_i = 5'(d); src1_i = 5'(s1); src2_i = 5'(s2);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic run_op(input bit dbl, input int len, input int str,
                        input int d, input int s1, input int s2);
    int step, n;
    bit legal;
    string rq;
    step  = (str == 0) ? 1 : (str == 3) ? 2 : 0;
    legal = (step != 0) && (!dbl || (len >= 1 && len <= 3));
    n     = !legal ? 0 : low_bank(d, dbl) ? 1 : len + 1;
    rq    = dbl ? "R3" : "R2";
    drive_start(dbl, len, str, d, s1, s2);
    if (!legal) begin
      chk(illegal_o && !busy_o && !iter_vld_o, (step == 0) ? "R7" : "R8",
          "illegal pulse with no iteration", {illegal_o, iter_vld_o}, 2);
      @(negedge clk_i);
      chk(!illegal_o && !iter_vld_o, "R9", "illegal pulse length",
          {illegal_o, iter_vld_o}, 0);
      return;
    end
    for (int k = 0; k < n; k++) begin
      int ed, e1, e2;
      ed = exp_idx(d,  dbl, step, k, 1'b0);
      e1 = exp_idx(s1, dbl, step, k, low_bank(s1, dbl));
      e2 = exp_idx(s2, dbl, step, k, low_bank(s2, dbl));
      chk(iter_vld_o && busy_o && (iter_last_o == (k == n - 1)), "R6",
          "valid/last", {iter_vld_o, iter_last_o}, {1'b1, k == n - 1});
      chk(dst_o == 5'(ed) && src1_o == 5'(e1) && src2_o == 5'(e2), rq,
          "triple (dst*1024+s1*32+s2)", dst_o * 1024 + src1_o * 32 + src2_o,
          ed * 1024 + e1 * 32 + e2);
      if (low_bank(s1, dbl) || low_bank(s2, dbl))
        chk(src1_o == 5'(e1) && src2_o == 5'(e2), "R11", "held source",
            src1_o * 32 + src2_o, e1 * 32 + e2);
      chk(lin_dst_o == 5'((d + k * step) % 32), "R13", "linear index",
          lin_dst_o, (d + k * step) % 32);
      @(negedge clk_i);
    end
    chk(!iter_vld_o && !busy_o, (n == 1 && low_bank(d, dbl)) ? "R10" : "R4",
        "idle after count", {iter_vld_o, busy_o}, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int ed[6], e1[6], e2[6];
    ed = '{11, 12, 13, 14, 15, 8};
    e1 = '{22, 23, 16, 17, 18, 19};
    e2 = '{31, 24, 25, 26, 27, 28};

    // R1 reset state
    repeat (2) @(negedge clk_i);
    chk(!iter_vld_o && !iter_last_o && !busy_o && !illegal_o, "R1",
        "reset outputs", {iter_vld_o, iter_last_o, busy_o, illegal_o}, 0);
    rst_ni = 1'b1;

    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [20:0] e;
      e = VEC[v];
      run_op(e[20], int'(e[19:17]), int'(e[16:15]), int'(e[14:10]),
             int'(e[9:5]), int'(e[4:0]));
    end

    // R2 fixed six-step wrap sequence, R5 first result one cycle after start
    drive_start(1'b0, 5, 0, 11, 22, 31);
    for (int k = 0; k < 6; k++) begin
      chk(dst_o == 5'(ed[k]) && src1_o == 5'(e1[k]) && src2_o == 5'(e2[k]),
          "R2", "fixed wrap triple", dst_o * 1024 + src1_o * 32 + src2_o,
          ed[k] * 1024 + e1[k] * 32 + e2[k]);
      if (k == 0) chk(iter_vld_o, "R5", "first iteration timing", iter_vld_o, 1);
      @(negedge clk_i);
    end

    // R7 other reserved stride code
    run_op(1'b1, 2, 2, 8, 9, 10);
    // R8 double length 8
    run_op(1'b1, 7, 0, 8, 9, 10);

    // R12 start ignored mid-run and on the final iteration
    drive_start(1'b0, 5, 0, 11, 22, 31);
    for (int k = 0; k < 6; k++) begin
      chk(iter_vld_o && dst_o == 5'(ed[k]) && !illegal_o, "R12",
          "run unaffected by start", dst_o, ed[k]);
      if (k == 2 || k == 5) begin
        dbl_i = 1'b1; len_i = 3'd0; dst_i = 5'd7; start_i = 1'b1;
      end
      @(negedge clk_i);
      start_i = 1'b0;
    end
    chk(!iter_vld_o && !illegal_o, "R12", "no start after ignored pulse",
        {iter_vld_o, illegal_o}, 0);

    // R1 reset during a run
    drive_start(1'b0, 7, 0, 12, 13, 14);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(!iter_vld_o && !busy_o && !iter_last_o, "R1", "async reset mid-run",
        {iter_vld_o, busy_o, iter_last_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_op(1'b0, 1, 3, 31, 6, 15);

    finish_run();
  end
endmodule